// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block produces a glitch-free enable for one group of output clocks. It sits beside a reference clock and watches an active-low stop request from outside the clock domain. After the request is synchronized, the block parks the group's clock at logic 0 or lets it run again. A stopped clock always stops in its low phase. A restarted clock always begins with a complete high phase, so no runt pulse reaches a load.

The block enforces a minimum run time. Once the group is running, it delivers at least a set number of clock pulses before it honours another stop. The stop request is obeyed only when the low-power mode strap reads 0 at reset. With the strap at 1, the group runs unconditionally. The CPU group uses the default parameters: two synchronizer stages and a 100-pulse minimum. The PCI group uses one synchronizer stage and a 10-pulse minimum. Each group has its own instance, so gating one group leaves every other clock untouched.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, and after its release while `stop_req_n` stays high, `clk_en` is 1 and `gclk` copies `clk`.
- R2: `mode_sel` is captured on every rising edge while `rst_n` is low, and the captured value is kept until the next reset. When the captured value is 1, `stop_req_n` has no effect and `clk_en` stays 1. Changing `mode_sel` after reset is released has no effect.
- R3: The off-latency case assumes the captured mode is 0 and the minimum run is already met. If `stop_req_n` is low before rising edge k and held low, `gclk` pulses high at edges k through k+SYNC_STAGES-1 and not at edge k+SYNC_STAGES. With the defaults this is fewer than 4 cycles; with one stage it is one clock.
- R4: The on-latency case starts from a stopped group. If `stop_req_n` goes high before rising edge k, `gclk` stays low at edges k through k+SYNC_STAGES-1. Its first pulse is the full high phase that starts at edge k+SYNC_STAGES.
- R5: While the group is stopped, `clk_en` and `gclk` are both held at 0.
- R6: After reset release, and after every restart, `gclk` delivers at least MIN_ON_CYCLES high pulses before it stops. If the stop request is low throughout, or returns low before the minimum has elapsed, exactly MIN_ON_CYCLES pulses are delivered and then the clock stops.
- R7: `clk_en` changes only while `clk` is low, so it is stable through every high phase, and `gclk` is never high while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the gated group |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Mode strap sampled during reset: 0 obeys stop requests, 1 ignores them |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| clk_en | output | 1 | Gating enable, updated on the falling edge of `clk` |
| gclk | output | 1 | Gated clock, `clk` qualified by `clk_en` |

## Verification
The assertions assume that reset is held across at least one falling edge, so the falling-edge enable register starts at 1. They also assume `mode_sel` matters only while reset is low. The stimulus keeps to both assumptions: it holds reset for several cycles, and it moves the stop request and the strap only in the middle of a high phase. That keeps every synchronizer sample and every falling-edge decision unambiguous. Pulse counts and latencies are measured on `gclk` at mid-high phase. A separate monitor watches `clk_en` across each high phase for any change.

// File: rtl/clkstop_pkg.sv
// Shared types and helpers for the clock stop gate.
// Assumes: none beyond IEEE 1800-2017 elaboration.
package clkstop_pkg;

    // Mode strap captured during reset.
    typedef enum logic {
        STRAP_MOBILE  = 1'b0,
        STRAP_DESKTOP = 1'b1
    } strap_mode_e;

    // Bits needed to count from 0 up to n inclusive.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
// Synchronizer for the asynchronous active-low stop request.
// Output run_sync is 1 when the request line is high (clocks may run).
// Assumes: STAGES >= 1; resets to the running state.
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic run_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop for the fast-response variant.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= async_n;
            end
        end else begin : g_multi
            // Shift the request through the metastability chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign run_sync = chain[STAGES-1];

endmodule

// File: rtl/clkstop_mincnt.sv
// Counts gated pulses delivered since the enable last rose, saturating at MIN_ON.
// min_done tells the decision logic that a stop may now be honoured.
// Assumes: en_live is the falling-edge enable, stable at each rising edge.
module clkstop_mincnt
    import clkstop_pkg::*;
#(
    parameter int MIN_ON = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_live,
    output logic min_done
);

    localparam int CW = cnt_bits(MIN_ON);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_ON);

    logic [CW-1:0] cnt;

    // Count pulses while enabled and clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!en_live)   cnt <= '0;
        else if (cnt < LIMIT) cnt <= cnt + 1'b1;
    end

    assign min_done = (cnt >= LIMIT);

    // R6: the count never passes the minimum-run limit.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R6: a stopped cycle restarts the run count from zero.
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_live |=> (cnt == '0));

endmodule

// File: rtl/clkstop_gate_reg.sv
// Falling-edge enable register and output gate.
// The enable moves only while clk is low, so every gated high phase is whole.
// Assumes: reset is held across at least one falling edge.
module clkstop_gate_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    output logic en_q,
    output logic gclk
);

    // Capture the next enable in the low phase of the reference clock.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_next;
    end

    // Qualify the reference clock with the low-phase enable.
    assign gclk = clk & en_q;

endmodule

// File: rtl/clkstop_gate.sv
// Top of the clock stop gate for one output clock group.
// Synchronizes the stop request, enforces the minimum run and drives a
// glitch-free enable.
// Assumes: mode_sel is meaningful only while rst_n is low.
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int MIN_ON_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic stop_req_n,
    output logic clk_en,
    output logic gclk
);

    strap_mode_e mode_q;
    logic        run_sync;
    logic        min_done;
    logic        en_q;
    logic        en_next;

    // Capture the mode strap while reset is held and keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= strap_mode_e'(mode_sel);
    end

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_n  (stop_req_n),
        .run_sync (run_sync)
    );

    clkstop_mincnt #(.MIN_ON(MIN_ON_CYCLES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_live  (en_q),
        .min_done (min_done)
    );

    // Decide the next enable: run unless stopping is allowed and requested.
    always_comb begin
        if (mode_q == STRAP_DESKTOP) en_next = 1'b1;
        else if (run_sync)           en_next = 1'b1;
        else                         en_next = en_q && !min_done;
    end

    clkstop_gate_reg u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_next (en_next),
        .en_q    (en_q),
        .gclk    (gclk)
    );

    assign clk_en = en_q;

    // R2: the strap value does not move once reset is released.
    p_mode_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    // R2: with the run-always strap the group is never stopped.
    p_desktop_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == STRAP_DESKTOP) |-> en_q);

    // R6: a stop is taken only after the minimum run has been delivered.
    p_min_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_q) && !en_q) |-> min_done);

    // R4: a restart happens only on a synchronized run request.
    p_restart_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> (run_sync || mode_q == STRAP_DESKTOP));

endmodule

// File: tb/clkstop_gate_test.sv
`timescale 1ns/1ps
module clkstop_gate_test;

    localparam int CPU_S = 2;
    localparam int CPU_MIN = 100;
    localparam int PCI_S = 1;
    localparam int PCI_MIN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic cpu_en, cpu_gclk, pci_en, pci_gclk;

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    int lowphase_hi = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkstop_gate uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .stop_req_n(cpu_stop_n), .clk_en(cpu_en), .gclk(cpu_gclk)
    );

    clkstop_gate #(.SYNC_STAGES(PCI_S), .MIN_ON_CYCLES(PCI_MIN)) uut_pci (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .stop_req_n(pci_stop_n), .clk_en(pci_en), .gclk(pci_gclk)
    );

    // R7 monitor: enables stable across each high phase, gated clocks low in low phase.
    always @(posedge clk) begin
        logic a, b;
        #2;
        a = cpu_en;
        b = pci_en;
        #6;
        if (cpu_en !== a || pci_en !== b) glitches++;
    end
    always @(negedge clk) begin
        #5;
        if (cpu_gclk !== 1'b0 || pci_gclk !== 1'b0) lowphase_hi++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to mid-high phase of the next cycle.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    function automatic logic g(input bit pci);
        return pci ? pci_gclk : cpu_gclk;
    endfunction

    task automatic drive(input bit pci, input logic v);
        if (pci) pci_stop_n = v;
        else     cpu_stop_n = v;
    endtask

    task automatic do_reset(input logic mode, input logic cs, input logic ps);
        tick();
        rst_n = 1'b0;
        mode_sel = mode;
        cpu_stop_n = cs;
        pci_stop_n = ps;
        repeat (4) tick();
        rst_n = 1'b1;
    endtask

    // R1: enables high in reset and afterwards with no stop request.
    task automatic t_reset_state();
        do_reset(1'b0, 1'b1, 1'b1);
        rst_n = 1'b0;
        tick();
        chk(cpu_en === 1'b1 && pci_en === 1'b1, "R1 enable in reset", int'(cpu_en), 1);
        chk(cpu_gclk === 1'b1 && pci_gclk === 1'b1, "R1 gclk in reset", int'(cpu_gclk), 1);
        rst_n = 1'b1;
        repeat (20) tick();
        chk(cpu_en === 1'b1 && pci_en === 1'b1, "R1 enable after release", int'(cpu_en), 1);
        chk(cpu_gclk === 1'b1 && pci_gclk === 1'b1, "R1 gclk after release", int'(cpu_gclk), 1);
    endtask

    // R6/R5: stop held low from reset gives exactly the minimum run, then low.
    task automatic t_min_after_reset();
        int nc, np;
        bit cdone, pdone;
        nc = 0; np = 0; cdone = 0; pdone = 0;
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < CPU_MIN + 30; i++) begin
            tick();
            if (cpu_gclk && !cdone) nc++; else cdone = 1;
            if (pci_gclk && !pdone) np++; else pdone = 1;
        end
        chk(nc == CPU_MIN, "R6 cpu run after reset", nc, CPU_MIN);
        chk(np == PCI_MIN, "R6 pci run after reset", np, PCI_MIN);
        chk(cpu_en === 1'b0 && cpu_gclk === 1'b0, "R5 cpu held low", int'(cpu_en), 0);
        chk(pci_en === 1'b0 && pci_gclk === 1'b0, "R5 pci held low", int'(pci_en), 0);
    endtask

    // R4: first pulse comes S edges after the request rises, none before.
    task automatic t_on_latency(input bit pci, input int s);
        int early;
        early = 0;
        drive(pci, 1'b1);
        for (int i = 0; i < s; i++) begin
            tick();
            if (g(pci)) early++;
        end
        chk(early == 0, pci ? "R4 pci no early pulse" : "R4 cpu no early pulse", early, 0);
        tick();
        chk(g(pci) === 1'b1, pci ? "R4 pci first pulse" : "R4 cpu first pulse", int'(g(pci)), 1);
        repeat (CPU_MIN + 20) tick();
    endtask

    // R3/R5: S more pulses after the request falls, then held low.
    task automatic t_off_latency(input bit pci, input int s);
        int ones, late;
        ones = 0; late = 0;
        drive(pci, 1'b0);
        for (int i = 0; i < s; i++) begin
            tick();
            if (g(pci)) ones++;
        end
        chk(ones == s, pci ? "R3 pci pulses before stop" : "R3 cpu pulses before stop", ones, s);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (g(pci)) late++;
        end
        chk(late == 0, pci ? "R5 pci stopped" : "R5 cpu stopped", late, 0);
    endtask

    // R6: a short run request still yields the full minimum run.
    task automatic t_early_stop(input bit pci, input int mn);
        int ones;
        ones = 0;
        drive(pci, 1'b1);
        for (int i = 0; i < 3; i++) begin
            tick();
            if (g(pci)) ones++;
        end
        drive(pci, 1'b0);
        for (int i = 0; i < mn + 20; i++) begin
            tick();
            if (g(pci)) ones++;
        end
        chk(ones == mn, pci ? "R6 pci short request" : "R6 cpu short request", ones, mn);
    endtask

    // R2: run-always strap ignores stop requests and later strap changes.
    task automatic t_desktop();
        int zc, zp;
        zc = 0; zp = 0;
        do_reset(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < CPU_MIN + 50; i++) begin
            tick();
            if (!cpu_gclk) zc++;
            if (!pci_gclk) zp++;
        end
        chk(zc == 0 && zp == 0, "R2 stop ignored in run-always mode", zc + zp, 0);
        mode_sel = 1'b0;
        zc = 0; zp = 0;
        for (int i = 0; i < CPU_MIN + 50; i++) begin
            tick();
            if (!cpu_gclk) zc++;
            if (!pci_gclk) zp++;
        end
        chk(zc == 0 && zp == 0, "R2 strap change after reset ignored", zc + zp, 0);
    endtask

    initial begin
        t_reset_state();
        t_min_after_reset();
        t_on_latency(1'b0, CPU_S);
        t_off_latency(1'b0, CPU_S);
        t_on_latency(1'b1, PCI_S);
        t_off_latency(1'b1, PCI_S);
        t_early_stop(1'b0, CPU_MIN);
        t_early_stop(1'b1, PCI_MIN);
        t_desktop();
        chk(glitches == 0, "R7 enable moved in high phase", glitches, 0);
        chk(lowphase_hi == 0, "R7 gclk high in low phase", lowphase_hi, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule